// File: doc/BRIEF.md
# Read Address Pointer Controller with Deferred Reset

This block owns the sequential read address of a field-sized serial memory, running entirely in the read clock domain. While the read enable is high, the pointer advances by one location per clock. Once it reaches the top of the address space it wraps back to zero. A rising edge on a reset strobe returns the pointer to address zero. The strobe may arrive without any timing relation to the read clock, so it first passes through a synchroniser and an edge detector.

A recognised reset only takes effect on a clock in which reading is enabled. If read enable is low when the edge is seen, the reset waits as a pending request and is applied at the first enabled clock. The block also counts the enabled read clocks between two applied resets. If a new reset arrives after fewer than the minimum count, it raises a sticky protocol-violation flag. A registered output-valid signal tells the downstream data path when a read word should be presented.

Top module: `rdptr_ctl`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_addr_o` is 0, `rd_valid_o` is 0 and `viol_o` is 0.
- R2: On each rising clock edge at which `re_i` is 1 and no reset is applied, `rd_addr_o` increases by exactly one.
- R3: On a rising clock edge at which `re_i` is 0, `rd_addr_o` keeps its value.
- R4: An advance from address DEPTH-1 (default 245759) produces address 0.
- R5: Suppose `rstr_i` is sampled 0 at edge k-1 and 1 at edge k. Then a reset is recognised at edge k+2, which is two synchroniser flops plus one edge-detect flop. If `re_i` is 1 at that edge, `rd_addr_o` becomes 0.
- R6: If `re_i` is 0 at the recognising edge, the reset stays pending and `rd_addr_o` holds. The reset is applied, and the address becomes 0, at the first later edge at which `re_i` is 1.
- R7: Holding `rstr_i` high causes exactly one reset. Another reset needs `rstr_i` to be sampled low for at least one edge first.
- R8: `viol_o` is set when an applied reset follows the previous applied reset with fewer than MIN_GAP (default 20) enabled, non-reset clocks between them. The first reset after `rst_n` never sets it. Once set, it stays at 1 until `rst_n` is asserted.
- R9: `rd_valid_o` equals `re_i AND oe_i` as sampled at the previous rising edge.
- R10: `rd_addr_o` is always less than DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstr_i | input | 1 | Reset-read strobe, may be asynchronous |
| re_i | input | 1 | Read enable; advances pointer, gates reset application |
| oe_i | input | 1 | Output enable |
| rd_addr_o | output | ADDR_W ($clog2(DEPTH)) | Current read address |
| rd_valid_o | output | 1 | Registered read-and-output enable |
| viol_o | output | 1 | Sticky reset-spacing violation flag |

## Verification
On every cycle, the assertions check the address step with its wrap, the hold while disabled, and the return to zero when a reset is applied. They also check that a reset is never applied with read enable low, that a pending request persists, that edge recognition is one-shot, that the violation flag is sticky and that the valid output is delayed correctly. The end-to-end strobe latency through the synchroniser, the postponement across several disabled cycles and the counting of the spacing rule show up only in the bench's directed scenarios and its cycle-by-cycle reference model.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;
  // Successor of a read address in a space of depth locations.
  function automatic int unsigned rdptr_next(input int unsigned addr, input int unsigned depth);
    return (addr >= depth - 1) ? 0 : addr + 1;
  endfunction

  // True when an applied reset comes too soon after the previous one.
  function automatic logic rdptr_gap_short(input int unsigned gap, input int unsigned min_gap,
                                           input logic seen);
    return seen && (gap < min_gap);
  endfunction
endpackage

// File: rtl/rdptr_sync.sv
module rdptr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d_i};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= d_i;
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/rdptr_rst_track.sv
module rdptr_rst_track (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_s,
  input  logic re_i,
  output logic rise_o,
  output logic apply_o,
  output logic pend_o
);
  logic strobe_d;
  logic pend_q;
  logic req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b0;
    else        strobe_d <= strobe_s;
  end

  assign rise_o  = strobe_s & ~strobe_d;
  assign req     = rise_o | pend_q;
  assign apply_o = req & re_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req & ~re_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rdptr_spacing.sv
module rdptr_spacing #(
  parameter int MIN_GAP = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic apply_i,
  input  logic re_i,
  output logic viol_o
);
  import rdptr_pkg::*;
  localparam int CNT_W = $clog2(MIN_GAP + 1);

  logic [CNT_W-1:0] gap_q;
  logic             seen_q;
  logic             viol_q;
  logic             too_soon;

  assign too_soon = rdptr_gap_short(32'(gap_q), MIN_GAP, seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      viol_q <= 1'b0;
    end else if (apply_i) begin
      if (too_soon) viol_q <= 1'b1;
      seen_q <= 1'b1;
      gap_q  <= '0;
    end else if (re_i && (gap_q < CNT_W'(MIN_GAP))) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/rdptr_ctl.sv
module rdptr_ctl #(
  parameter int DEPTH       = 245760,
  parameter int MIN_GAP     = 20,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rstr_i,
  input  logic              re_i,
  input  logic              oe_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_valid_o,
  output logic              viol_o
);
  import rdptr_pkg::*;

  logic              strobe_s;
  logic              strobe_rise;
  logic              reset_apply;
  logic              reset_pend;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  rdptr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rstr_i), .q_o(strobe_s)
  );

  rdptr_rst_track u_track (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .re_i(re_i),
    .rise_o(strobe_rise), .apply_o(reset_apply), .pend_o(reset_pend)
  );

  rdptr_spacing #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .apply_i(reset_apply), .re_i(re_i), .viol_o(viol_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (reset_apply) addr_q <= '0;
    else if (re_i)        addr_q <= ADDR_W'(rdptr_next(32'(addr_q), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= re_i & oe_i;
  end

  assign rd_addr_o  = addr_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/rdptr_ctl_chk.sv
module rdptr_ctl_chk #(
  parameter int DEPTH  = 245760,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              re_i,
  input logic              oe_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_o,
  input logic              viol_o,
  input logic              rise,
  input logic              apply,
  input logic              pend
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (re_i && !apply) |=> (int'(rd_addr_o) ==
      ((int'($past(rd_addr_o)) == DEPTH - 1) ? 0 : int'($past(rd_addr_o)) + 1)));

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !re_i |=> $stable(rd_addr_o));

  // R5
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    apply |=> (rd_addr_o == '0));

  // R6
  apply_needs_re_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    apply |-> re_i);

  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (pend && !re_i) |=> pend);

  // R7
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rise |=> !rise);

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    viol_o |=> viol_o);

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |=> (rd_valid_o == $past(re_i && oe_i)));

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_addr_o) < DEPTH);
endmodule

bind rdptr_ctl rdptr_ctl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .re_i(re_i), .oe_i(oe_i), .rd_addr_o(rd_addr_o),
  .rd_valid_o(rd_valid_o), .viol_o(viol_o), .rise(strobe_rise),
  .apply(reset_apply), .pend(reset_pend)
);

// File: tb/tb_rdptr_ctl.sv
module tb_rdptr_ctl;
  localparam int PERIOD  = 10;
  localparam int DEPTH   = 40;
  localparam int MIN_GAP = 20;
  localparam int ADDR_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rstr = 1'b0, re = 1'b0, oe = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic valid, viol;

  int checks = 0, errors = 0;

  // reference model state
  bit hist[$] = '{0, 0, 0, 0};
  int m_addr = 0, m_gap = 0;
  bit m_pend = 0, m_seen = 0, m_viol = 0, m_valid = 0;

  rdptr_ctl #(.DEPTH(DEPTH), .MIN_GAP(MIN_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .rstr_i(rstr), .re_i(re), .oe_i(oe),
    .rd_addr_o(addr), .rd_valid_o(valid), .viol_o(viol)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rise, req;
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_addr = 0; m_gap = 0; m_pend = 0; m_seen = 0; m_viol = 0; m_valid = 0;
      return;
    end
    hist.push_front(rstr);
    void'(hist.pop_back());
    rise = hist[2] && !hist[3];
    req = rise || m_pend;
    if (req && re) begin
      if (m_seen && m_gap < MIN_GAP) m_viol = 1;
      m_seen = 1; m_gap = 0; m_addr = 0; m_pend = 0;
    end else begin
      m_pend = req;
      if (re) begin
        m_addr = (m_addr + 1) % DEPTH;
        m_gap++;
      end
    end
    m_valid = re && oe;
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R2 model address", int'(addr), m_addr);
      check("R9 model valid", int'(valid), int'(m_valid));
      check("R8 model violation", int'(viol), int'(m_viol));
      check("R10 range", int'(int'(addr) < DEPTH), 1);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick(3);
    check("R1 reset addr", int'(addr), 0);
    check("R1 reset valid", int'(valid), 0);
    check("R1 reset viol", int'(viol), 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 after release addr", int'(addr), 0);

    re = 1; oe = 1;
    tick(10);
    check("R2 ten advances", int'(addr), 10);

    re = 0;
    tick(5);
    check("R3 hold while disabled", int'(addr), 10);

    re = 1;
    tick(29);
    check("R4 top address", int'(addr), DEPTH - 1);
    tick(1);
    check("R4 wrap to zero", int'(addr), 0);

    tick(3);
    rstr = 1;
    tick(2);
    check("R5 not yet recognised", int'(addr), 5);
    tick(1);
    check("R5 reset applied", int'(addr), 0);
    check("R8 first reset no flag", int'(viol), 0);
    tick(5);
    check("R7 held strobe one reset", int'(addr), 5);
    rstr = 0;

    tick(25);
    check("R2 long run", int'(addr), 30);
    re = 0;
    rstr = 1;
    tick(1);
    rstr = 0;
    tick(6);
    check("R6 pending holds address", int'(addr), 30);
    re = 1;
    tick(1);
    check("R6 pending applied", int'(addr), 0);
    check("R8 spaced resets no flag", int'(viol), 0);
    tick(1);
    check("R6 advance after apply", int'(addr), 1);

    rstr = 1;
    tick(1);
    rstr = 0;
    tick(2);
    check("R5 second reset", int'(addr), 0);
    check("R8 close resets flag", int'(viol), 1);
    re = 0;
    tick(4);
    check("R8 flag sticky", int'(viol), 1);

    re = 1; oe = 0;
    tick(1);
    check("R9 oe low", int'(valid), 0);
    re = 0; oe = 1;
    tick(1);
    check("R9 re low", int'(valid), 0);
    re = 1; oe = 1;
    tick(1);
    check("R9 both high", int'(valid), 1);

    rst_n = 0;
    tick(2);
    rst_n = 1;
    re = 0; oe = 0;
    tick(1);
    check("R8 cleared by reset", int'(viol), 0);
    check("R1 addr after second reset", int'(addr), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule